// File: doc/BRIEF.md
# Associative Transaction Queue

This block holds a fixed number of outstanding memory transactions between an address-translation stage and a scheduling processor. Each slot stores the DRAM coordinates of a transaction, an immutable key written once at enqueue, and a mutable key. The mutable key joins eight flags owned by software with six flags that external hardware recomputes every cycle and supplies per slot as input bits. New transactions enter through a valid/ready port into the lowest-numbered free slot. Their software flags start from a snapshot of the DRAM subsystem state that is present on an input in the enqueue cycle.

The processor side issues associative searches. A search carries a pattern and a care mask for each of the two keys, and it compares only the valid slots. All slots are compared in parallel in one cycle. One registered response reports the number of matching slots and the contents of the oldest matching slot, where oldest means earliest enqueued, whatever its slot number. An update search also overwrites the software flags and the coordinates of that oldest match. A separate invalidate port retires a slot by its index.

Top module: `tq_assoc_queue`

## Requirements
- R1: `enq_ready` is low exactly when every slot is valid. An enqueue offered while `enq_ready` is low stores nothing.
- R2: An accepted enqueue fills the lowest-numbered free slot. It stores `enq_fkey`, `enq_coord` and, as the software flags, the value of `dram_state` in that cycle.
- R3: A slot matches when it is valid, `((fkey ^ srch_fpat) & srch_fmask) == 0`, and `((vkey ^ srch_vpat) & srch_vmask) == 0`. Here vkey bits [7:0] are the software flags and bits [13:8] are the slot's hardware flags, taken from `hw_flags[slot*6 +: 6]`.
- R4: When several slots match, the response selects the slot enqueued earliest, not the lowest index.
- R5: One cycle after `srch_valid`, `rsp_valid` is high, and `rsp_idx`, `rsp_fkey`, `rsp_vkey` and `rsp_coord` show the selected slot as it was in the search cycle. `rsp_valid` is low one cycle after a cycle without a search.
- R6: A search with `srch_op` = 1 (update) writes `upd_sw` into the selected slot's software flags and writes `upd_coord` into its coordinates. Its fixed key is unchanged, and its hardware flags still follow `hw_flags`. Ops 0 (load), 2 (count) and 3 write nothing.
- R7: `rsp_count` is the number of matching slots for every op.
- R8: A search with no match sets `rsp_miss` and returns zero on `rsp_idx`, `rsp_count` and all data fields. A missed update changes no slot.
- R9: `inv_valid` clears the valid bit of slot `inv_idx` at the next edge, so the slot stops matching and can be refilled. If an update targets the same slot in the same cycle, the invalidate wins.
- R10: After reset all slots are empty, `enq_ready` is high and `rsp_valid` is low.
- R11: Hardware flags are compared with their value in the search cycle, so a change on `hw_flags` alters the match result of the very next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue offer |
| enq_ready | output | 1 | A free slot exists |
| enq_fkey | input | FKEY_W | Fixed key of the new transaction |
| enq_coord | input | COORD_W | DRAM coordinates of the new transaction |
| dram_state | input | SW_W | Initial software flags for the new transaction |
| hw_flags | input | DEPTH*HW_W | Per-slot hardware flags, slot i at [i*HW_W +: HW_W] |
| srch_valid | input | 1 | Search request |
| srch_op | input | 2 | 0 load, 1 update, 2 count, 3 load |
| srch_fpat | input | FKEY_W | Fixed-key pattern |
| srch_fmask | input | FKEY_W | Fixed-key care mask |
| srch_vpat | input | SW_W+HW_W | Variable-key pattern |
| srch_vmask | input | SW_W+HW_W | Variable-key care mask |
| upd_sw | input | SW_W | New software flags for an update |
| upd_coord | input | COORD_W | New coordinates for an update |
| inv_valid | input | 1 | Retire request |
| inv_idx | input | $clog2(DEPTH) | Slot to retire |
| rsp_valid | output | 1 | Search response valid |
| rsp_miss | output | 1 | No slot matched |
| rsp_idx | output | $clog2(DEPTH) | Selected slot |
| rsp_fkey | output | FKEY_W | Fixed key of the selected slot |
| rsp_vkey | output | SW_W+HW_W | Variable key of the selected slot |
| rsp_coord | output | COORD_W | Coordinates of the selected slot |
| rsp_count | output | $clog2(DEPTH+1) | Number of matching slots |

## Verification
Every search result is registered, so it appears on the response port exactly one cycle after the search. That response reflects the slot contents, and the hardware flags, of the search cycle. Enqueue, update and invalidate take effect at the same edge, so they are seen first by a search in the following cycle. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares the outputs on the next falling edge. It uses a model built from the requirements, which records enqueue order, to give the expected oldest match and count.

// File: rtl/tq_pkg.sv
package tq_pkg;
   localparam int TQ_DEF_DEPTH = 8;
   localparam int TQ_DEF_SW_W  = 8;
   localparam int TQ_DEF_HW_W  = 6;

   typedef enum logic [1:0] {
      TQ_OP_LOAD   = 2'd0,
      TQ_OP_UPDATE = 2'd1,
      TQ_OP_COUNT  = 2'd2,
      TQ_OP_LOAD2  = 2'd3
   } tq_op_e;
endpackage

// File: rtl/tq_prio_enc.sv
module tq_prio_enc #(
   parameter  int N     = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             found
);
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tq_popcount.sv
module tq_popcount #(
   parameter  int N     = 8,
   localparam int CNT_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     vec,
   output logic [CNT_W-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(vec[i]);
   end
endmodule

// File: rtl/tq_match.sv
module tq_match #(
   parameter int DEPTH  = 8,
   parameter int FKEY_W = 8,
   parameter int VKEY_W = 14
) (
   input  logic [DEPTH-1:0]        vld,
   input  logic [DEPTH*FKEY_W-1:0] fkey_flat,
   input  logic [DEPTH*VKEY_W-1:0] vkey_flat,
   input  logic [FKEY_W-1:0]       fpat,
   input  logic [FKEY_W-1:0]       fmask,
   input  logic [VKEY_W-1:0]       vpat,
   input  logic [VKEY_W-1:0]       vmask,
   output logic [DEPTH-1:0]        hit
);
   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic f_ok, v_ok;
         assign f_ok   = ~|((fkey_flat[s*FKEY_W +: FKEY_W] ^ fpat) & fmask);
         assign v_ok   = ~|((vkey_flat[s*VKEY_W +: VKEY_W] ^ vpat) & vmask);
         assign hit[s] = vld[s] & f_ok & v_ok;
      end
   endgenerate
endmodule

// File: rtl/tq_age_order.sv
module tq_age_order #(
   parameter  int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] oldest_oh
);
   // before_q[a][b] set: slot a entered the queue ahead of slot b
   logic [DEPTH-1:0] before_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) before_q[a] <= '0;
      end else if (alloc_en) begin
         for (int a = 0; a < DEPTH; a++) begin
            if (IDX_W'(a) == alloc_idx) before_q[a] <= '0;
            else                        before_q[a][alloc_idx] <= 1'b1;
         end
      end
   end

   generate
      for (genvar b = 0; b < DEPTH; b++) begin : g_col
         logic [DEPTH-1:0] beaten;
         for (genvar a = 0; a < DEPTH; a++) begin : g_row
            assign beaten[a] = req[a] & before_q[a][b];
         end
         assign oldest_oh[b] = req[b] & ~|beaten;
      end
   endgenerate
endmodule

// File: rtl/tq_assoc_queue.sv
module tq_assoc_queue
   import tq_pkg::*;
#(
   parameter  int DEPTH   = TQ_DEF_DEPTH,
   parameter  int FKEY_W  = 8,
   parameter  int SW_W    = TQ_DEF_SW_W,
   parameter  int HW_W    = TQ_DEF_HW_W,
   parameter  int COORD_W = 24,
   localparam int VKEY_W  = SW_W + HW_W,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enq_valid,
   output logic                    enq_ready,
   input  logic [FKEY_W-1:0]       enq_fkey,
   input  logic [COORD_W-1:0]      enq_coord,
   input  logic [SW_W-1:0]         dram_state,
   input  logic [DEPTH*HW_W-1:0]   hw_flags,
   input  logic                    srch_valid,
   input  logic [1:0]              srch_op,
   input  logic [FKEY_W-1:0]       srch_fpat,
   input  logic [FKEY_W-1:0]       srch_fmask,
   input  logic [VKEY_W-1:0]       srch_vpat,
   input  logic [VKEY_W-1:0]       srch_vmask,
   input  logic [SW_W-1:0]         upd_sw,
   input  logic [COORD_W-1:0]      upd_coord,
   input  logic                    inv_valid,
   input  logic [IDX_W-1:0]        inv_idx,
   output logic                    rsp_valid,
   output logic                    rsp_miss,
   output logic [IDX_W-1:0]        rsp_idx,
   output logic [FKEY_W-1:0]       rsp_fkey,
   output logic [VKEY_W-1:0]       rsp_vkey,
   output logic [COORD_W-1:0]      rsp_coord,
   output logic [CNT_W-1:0]        rsp_count
);
   generate
      if (DEPTH < 2)   begin : g_bad_depth $error("tq_assoc_queue: DEPTH must be at least 2"); end
      if (FKEY_W < 1)  begin : g_bad_fkey  $error("tq_assoc_queue: FKEY_W must be positive"); end
      if (SW_W < 1)    begin : g_bad_sw    $error("tq_assoc_queue: SW_W must be positive"); end
      if (HW_W < 1)    begin : g_bad_hw    $error("tq_assoc_queue: HW_W must be positive"); end
      if (COORD_W < 1) begin : g_bad_coord $error("tq_assoc_queue: COORD_W must be positive"); end
   endgenerate

   logic [DEPTH-1:0]        vld_q;
   logic [FKEY_W-1:0]       fkey_q  [DEPTH];
   logic [SW_W-1:0]         sw_q    [DEPTH];
   logic [COORD_W-1:0]      coord_q [DEPTH];

   logic [DEPTH*FKEY_W-1:0] fkey_flat;
   logic [DEPTH*VKEY_W-1:0] vkey_flat;
   logic [DEPTH-1:0]        hit, oldest_oh;
   logic [IDX_W-1:0]        free_idx, sel_idx;
   logic                    free_any, sel_any;
   logic [CNT_W-1:0]        hit_cnt;
   logic                    enq_fire, upd_fire, inv_fire;

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_flat
         assign fkey_flat[s*FKEY_W +: FKEY_W] = fkey_q[s];
         assign vkey_flat[s*VKEY_W +: VKEY_W] = {hw_flags[s*HW_W +: HW_W], sw_q[s]};
      end
   endgenerate

   tq_prio_enc #(.N(DEPTH)) u_free (
      .vec   (~vld_q),
      .idx   (free_idx),
      .found (free_any)
   );

   tq_match #(.DEPTH(DEPTH), .FKEY_W(FKEY_W), .VKEY_W(VKEY_W)) u_match (
      .vld       (vld_q),
      .fkey_flat (fkey_flat),
      .vkey_flat (vkey_flat),
      .fpat      (srch_fpat),
      .fmask     (srch_fmask),
      .vpat      (srch_vpat),
      .vmask     (srch_vmask),
      .hit       (hit)
   );

   tq_age_order #(.DEPTH(DEPTH)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (enq_fire),
      .alloc_idx (free_idx),
      .req       (hit),
      .oldest_oh (oldest_oh)
   );

   tq_prio_enc #(.N(DEPTH)) u_sel (
      .vec   (oldest_oh),
      .idx   (sel_idx),
      .found (sel_any)
   );

   tq_popcount #(.N(DEPTH)) u_cnt (
      .vec (hit),
      .cnt (hit_cnt)
   );

   assign enq_ready = free_any;
   assign enq_fire  = enq_valid & free_any;
   assign upd_fire  = srch_valid & (tq_op_e'(srch_op) == TQ_OP_UPDATE) & sel_any;
   assign inv_fire  = inv_valid & (int'(inv_idx) < DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int s = 0; s < DEPTH; s++) begin
            fkey_q[s]  <= '0;
            sw_q[s]    <= '0;
            coord_q[s] <= '0;
         end
      end else begin
         if (enq_fire) begin
            vld_q[free_idx]   <= 1'b1;
            fkey_q[free_idx]  <= enq_fkey;
            sw_q[free_idx]    <= dram_state;
            coord_q[free_idx] <= enq_coord;
         end
         if (upd_fire) begin
            sw_q[sel_idx]    <= upd_sw;
            coord_q[sel_idx] <= upd_coord;
         end
         if (inv_fire) vld_q[inv_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_idx   <= '0;
         rsp_fkey  <= '0;
         rsp_vkey  <= '0;
         rsp_coord <= '0;
         rsp_count <= '0;
      end else begin
         rsp_valid <= srch_valid;
         if (srch_valid) begin
            rsp_miss  <= ~sel_any;
            rsp_count <= hit_cnt;
            rsp_idx   <= sel_any ? sel_idx : '0;
            rsp_fkey  <= sel_any ? fkey_q[sel_idx] : '0;
            rsp_vkey  <= sel_any ? vkey_flat[sel_idx*VKEY_W +: VKEY_W] : '0;
            rsp_coord <= sel_any ? coord_q[sel_idx] : '0;
         end
      end
   end
endmodule

// File: rtl/tq_assoc_queue_chk.sv
module tq_assoc_queue_chk #(
   parameter  int DEPTH  = 8,
   parameter  int FKEY_W = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    enq_valid,
   input logic                    enq_ready,
   input logic                    enq_fire,
   input logic                    srch_valid,
   input logic                    rsp_valid,
   input logic                    rsp_miss,
   input logic [CNT_W-1:0]        rsp_count,
   input logic                    inv_valid,
   input logic [IDX_W-1:0]        inv_idx,
   input logic [DEPTH-1:0]        vld_q,
   input logic [DEPTH*FKEY_W-1:0] fkey_flat
);
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_ready && !inv_valid) |=> $stable(vld_q)); // R1

   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      srch_valid |=> rsp_valid); // R5

   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_valid |=> !rsp_valid); // R5

   AST_MISS_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_count == '0)); // R8

   AST_HIT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> (rsp_count != '0)); // R7

   AST_FKEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !enq_fire |=> $stable(fkey_flat)); // R6

   AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && vld_q[inv_idx]) |=> !vld_q[$past(inv_idx)]); // R9

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (int'(rsp_count) <= DEPTH)); // R7
endmodule

bind tq_assoc_queue tq_assoc_queue_chk #(.DEPTH(DEPTH), .FKEY_W(FKEY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enq_valid  (enq_valid),
   .enq_ready  (enq_ready),
   .enq_fire   (enq_fire),
   .srch_valid (srch_valid),
   .rsp_valid  (rsp_valid),
   .rsp_miss   (rsp_miss),
   .rsp_count  (rsp_count),
   .inv_valid  (inv_valid),
   .inv_idx    (inv_idx),
   .vld_q      (vld_q),
   .fkey_flat  (fkey_flat)
);

// File: tb/sim_tq_assoc_queue.sv
`timescale 1ns/1ps
module sim_tq_assoc_queue;
   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid = 1'b0;
   logic        enq_ready;
   logic [7:0]  enq_fkey = '0;
   logic [23:0] enq_coord = '0;
   logic [7:0]  dram_state = '0;
   logic [47:0] hw_in = '0;
   logic        srch_valid = 1'b0;
   logic [1:0]  srch_op = '0;
   logic [7:0]  srch_fpat = '0, srch_fmask = '0;
   logic [13:0] srch_vpat = '0, srch_vmask = '0;
   logic [7:0]  upd_sw = '0;
   logic [23:0] upd_coord = '0;
   logic        inv_valid = 1'b0;
   logic [2:0]  inv_idx = '0;
   logic        rsp_valid, rsp_miss;
   logic [2:0]  rsp_idx;
   logic [7:0]  rsp_fkey;
   logic [13:0] rsp_vkey;
   logic [23:0] rsp_coord;
   logic [3:0]  rsp_count;

   int n_chk = 0;
   int n_fail = 0;

   logic        m_vld [D];
   logic [7:0]  m_fk  [D];
   logic [7:0]  m_sw  [D];
   logic [23:0] m_co  [D];
   int          m_seq [D];
   int          seq_ctr = 0;

   always #5 clk = ~clk;

   tq_assoc_queue u0 (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_fkey(enq_fkey),
      .enq_coord(enq_coord), .dram_state(dram_state), .hw_flags(hw_in),
      .srch_valid(srch_valid), .srch_op(srch_op), .srch_fpat(srch_fpat),
      .srch_fmask(srch_fmask), .srch_vpat(srch_vpat), .srch_vmask(srch_vmask),
      .upd_sw(upd_sw), .upd_coord(upd_coord),
      .inv_valid(inv_valid), .inv_idx(inv_idx),
      .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_idx(rsp_idx),
      .rsp_fkey(rsp_fkey), .rsp_vkey(rsp_vkey), .rsp_coord(rsp_coord),
      .rsp_count(rsp_count)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic enq(input logic [7:0] fk, input logic [7:0] st, input logic [23:0] co, input string rq);
      int slot = -1;
      for (int i = D - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
      chk(rq, "enq_ready", 32'(enq_ready), 32'(slot >= 0));
      enq_valid = 1'b1; enq_fkey = fk; dram_state = st; enq_coord = co;
      @(negedge clk);
      enq_valid = 1'b0;
      if (slot >= 0) begin
         m_vld[slot] = 1'b1; m_fk[slot] = fk; m_sw[slot] = st; m_co[slot] = co;
         m_seq[slot] = seq_ctr; seq_ctr++;
      end
   endtask

   task automatic inval(input int idx);
      inv_valid = 1'b1; inv_idx = 3'(idx);
      @(negedge clk);
      inv_valid = 1'b0;
      m_vld[idx] = 1'b0;
   endtask

   task automatic srch(input logic [1:0] op, input logic [7:0] fp, input logic [7:0] fm,
                       input logic [13:0] vp, input logic [13:0] vm,
                       input logic [7:0] usw, input logic [23:0] uco, input string rq);
      int ecnt = 0;
      int eidx = -1;
      int best = 0;
      for (int i = 0; i < D; i++) begin
         logic [13:0] vk;
         vk = {hw_in[i*6 +: 6], m_sw[i]};
         if (m_vld[i] && (((m_fk[i] ^ fp) & fm) == 8'h0) && (((vk ^ vp) & vm) == 14'h0)) begin
            ecnt++;
            if (eidx < 0 || m_seq[i] < best) begin eidx = i; best = m_seq[i]; end
         end
      end
      srch_valid = 1'b1; srch_op = op; srch_fpat = fp; srch_fmask = fm;
      srch_vpat = vp; srch_vmask = vm; upd_sw = usw; upd_coord = uco;
      @(negedge clk);
      srch_valid = 1'b0;
      chk(rq, "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(rq, "rsp_miss", 32'(rsp_miss), 32'(eidx < 0));
      chk(rq, "rsp_count", 32'(rsp_count), 32'(ecnt));
      if (eidx >= 0) begin
         chk(rq, "rsp_idx", 32'(rsp_idx), 32'(eidx));
         chk(rq, "rsp_fkey", 32'(rsp_fkey), 32'(m_fk[eidx]));
         chk(rq, "rsp_vkey", 32'(rsp_vkey), 32'({hw_in[eidx*6 +: 6], m_sw[eidx]}));
         chk(rq, "rsp_coord", 32'(rsp_coord), 32'(m_co[eidx]));
         if (op == 2'd1) begin m_sw[eidx] = usw; m_co[eidx] = uco; end
      end else begin
         chk(rq, "rsp_idx", 32'(rsp_idx), 32'd0);
         chk(rq, "rsp_data", 32'(rsp_fkey) | 32'(rsp_vkey) | 32'(rsp_coord), 32'd0);
      end
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < D; i++) begin
         m_vld[i] = 1'b0; m_fk[i] = '0; m_sw[i] = '0; m_co[i] = '0; m_seq[i] = 0;
         hw_in[i*6 +: 6] = 6'((i * 11) & 63);
      end
      repeat (3) @(negedge clk);
      // R10: empty after reset
      chk("R10", "enq_ready", 32'(enq_ready), 32'd1);
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      srch(2'd2, 8'h00, 8'h00, 14'h0, 14'h0, 8'h0, 24'h0, "R10");

      // R2: fill every slot, lowest free first
      for (int i = 0; i < D; i++)
         enq(8'((i * 37 + 5) & 255), 8'((i * 29 + 1) & 255), 24'(24'h100000 + i * 24'h1357), "R2");
      for (int i = 0; i < D; i++)
         srch(2'd0, m_fk[i], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R2");

      // R1: full queue refuses an enqueue
      chk("R1", "enq_ready_full", 32'(enq_ready), 32'd0);
      enq(8'hEE, 8'h00, 24'h0, "R1");
      srch(2'd0, 8'hEE, 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R1");

      // R3 / R7: fixed-key pattern and mask sweep
      for (int m = 0; m < 16; m++)
         for (int p = 0; p < 16; p++)
            srch(2'd2, {p[3:0], p[3:0]}, {m[3:0], ~m[3:0]}, 14'h0, 14'h0, 8'h0, 24'h0, "R3");
      // R3 / R7: variable-key sweep over hardware and software bits
      for (int m = 0; m < 64; m++)
         srch(2'd2, 8'h00, 8'h00, {m[5:0] ^ 6'h15, m[1:0], 6'h0}, {m[5:0], m[3:0], 4'h0}, 8'h0, 24'h0, "R7");

      // R4: oldest wins over lower index
      inval(1);
      enq(m_fk[6], 8'h5A, 24'hC0FFEE, "R4");
      srch(2'd0, m_fk[6], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R4");
      chk("R4", "oldest_idx", 32'(rsp_idx), 32'd6);
      inval(6);
      srch(2'd0, m_fk[1], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R4");
      chk("R4", "remaining_idx", 32'(rsp_idx), 32'd1);

      // R6: update writes soft flags and coordinates only
      srch(2'd1, m_fk[0], 8'hFF, 14'h0, 14'h0, 8'hFF, 24'hABCDEF, "R6");
      srch(2'd0, m_fk[0], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R6");
      chk("R6", "hw_part", 32'(rsp_vkey[13:8]), 32'(hw_in[5:0]));
      chk("R6", "coord", 32'(rsp_coord), 32'hABCDEF);
      srch(2'd2, m_fk[2], 8'hFF, 14'h0, 14'h0, 8'h11, 24'h111111, "R6");
      srch(2'd0, m_fk[2], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R6");

      // R11: live hardware flags
      hw_in[3*6 +: 6] = 6'h2A;
      srch(2'd2, 8'h00, 8'h00, {6'h2A, 8'h0}, {6'h3F, 8'h0}, 8'h0, 24'h0, "R11");
      hw_in[3*6 +: 6] = 6'h01;
      srch(2'd2, 8'h00, 8'h00, {6'h2A, 8'h0}, {6'h3F, 8'h0}, 8'h0, 24'h0, "R11");

      // R8: missed update leaves storage alone
      srch(2'd1, 8'hEE, 8'hFF, 14'h0, 14'h0, 8'h77, 24'h777777, "R8");
      for (int i = 0; i < D; i++)
         if (m_vld[i]) srch(2'd0, m_fk[i], 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R8");

      // R9: invalidate beats a same-cycle update of the same slot
      inv_valid = 1'b1; inv_idx = 3'd4;
      srch(2'd1, m_fk[4], 8'hFF, 14'h0, 14'h0, 8'h99, 24'h999999, "R9");
      inv_valid = 1'b0;
      m_vld[4] = 1'b0;
      srch(2'd0, 8'h00, 8'h00, 14'h0, 14'h0, 8'h0, 24'h0, "R9");
      srch(2'd2, 8'h00, 8'h00, 14'h0, 14'h0, 8'h0, 24'h0, "R9");
      enq(8'h3C, 8'h42, 24'h424242, "R9");
      srch(2'd0, 8'h3C, 8'hFF, 14'h0, 14'h0, 8'h0, 24'h0, "R9");
      chk("R9", "refill_idx", 32'(rsp_idx), 32'd4);

      // R5: response drops when no search follows
      @(negedge clk);
      chk("R5", "rsp_idle", 32'(rsp_valid), 32'd0);

      finish_run();
   end
endmodule